// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the raster timing for a display pipe. It runs on the pixel clock and divides it into character clocks of 8 pixels, or 16 pixels when double-width mode is selected. A character counter steps once per character clock, and a line counter steps once for each completed line. Both counters are compared against thresholds that are built from raw CRT controller bytes. Several of these thresholds are wider than 8 bits, so their upper bits are collected from overflow and extension bytes.

The outputs are horizontal sync, vertical sync, blanking and display enable. Each sync pin has a polarity chosen from the miscellaneous output byte. Software writes the register bytes in their usual biased encodings, and the block decodes them directly. Most fields are offset by a constant, and the sync and blank end points are narrow fields that are matched only against the low bits of the running counter. Pixel fetch, palette and DAC are outside the block.

Top module: `crtc_timing_gen`

## Requirements
- R1: One character clock lasts 8 pixel clocks while `dblWidth` is 0 and 16 pixel clocks while it is 1.
- R2: The character count per line is the horizontal total field plus 5. The counter runs from 0 to that count minus 1 and then returns to 0.
- R3: The line count per frame is the vertical total field plus 2. The line counter steps once when the character counter wraps.
- R4: `displayEnable` is high exactly when the character count is at most the display-end field and the line count is at most the vertical display-end field.
- R5: Horizontal sync turns on at the character equal to the 9-bit start field. It turns off at the first later character whose low 5 bits equal the end field. In the start character, turning on takes priority over a matching end.
- R6: Vertical sync follows the same rule per line. The start field is 11 bits wide and the end field of 4 bits is matched on the low 4 line bits.
- R7: Horizontal blanking follows the same rule, with a 9-bit start and a 7-bit end matched on the low 7 character bits. Vertical blanking uses an 11-bit start and an 8-bit end matched on the low 8 line bits. `blank` is the OR of the two.
- R8: While bit 7 of byte 0x17 is 0, both counters are held at 0, `blank` and `displayEnable` are low and both sync pins sit at their inactive level. Setting the bit starts timing at character 0 of line 0.
- R9: Miscellaneous bit 6 set makes horizontal sync active-high, and cleared makes it active-low. Bit 7 controls vertical sync in the same way.
- R10: Field assembly, with byte n at `crRegs[8n+7:8n]`:
  - Horizontal fields:
    - horizontal total is 0x00 with bit 8 from 0x1A[0]
    - display end is 0x01 with bit 8 from 0x1A[2]
    - blank start is 0x02 with bit 8 from 0x1A[4]
    - blank end is 0x03[4:0], with bit 5 from 0x05[7] and bit 6 from 0x1A[5]
    - sync start is 0x04 with bit 8 from 0x1A[6]
    - sync end is 0x05[4:0]
  - Vertical fields:
    - vertical total is 0x06, with bits 8, 9 and 10 from 0x07[0], 0x07[5] and 0x1B[0]
    - display end is 0x12, with bits 8, 9 and 10 from 0x07[1], 0x07[6] and 0x1B[2]
    - sync start is 0x10, with bits 8, 9 and 10 from 0x07[2], 0x07[7] and 0x1B[6]
    - blank start is 0x15, with bits 8, 9 and 10 from 0x07[3], 0x09[5] and 0x1B[4]
    - sync end is 0x11[3:0]
    - blank end is 0x16

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crRegs | input | 224 | CRT controller bytes 0x00 to 0x1B, byte n in bits 8n+7:8n |
| miscOut | input | 8 | Miscellaneous output byte, bits 6 and 7 select sync polarity |
| dblWidth | input | 1 | Selects 16-pixel character clocks |
| hSyncPin | output | 1 | Horizontal sync after polarity |
| vSyncPin | output | 1 | Vertical sync after polarity |
| blank | output | 1 | Horizontal or vertical blanking |
| displayEnable | output | 1 | Active picture area |

## Verification
The character counter's wrap and the line counter's step fall on the same pixel edge. At that edge the vertical sync and blank flags must also move. The bench checks every pixel of whole frames against a per-pixel expectation built from the requirements, so a one-pixel or one-line slip at this edge shows up at once. Configurations place vertical sync at line 0, and end vertical sync and blank exactly at the frame wrap. One configuration gives the horizontal sync start character low bits that equal the end field, so that turn-on and turn-off land in the same character. It is judged by the sync staying on until the next full 32-character match.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CR_COUNT    = 28;
  localparam int HF_W        = 9;
  localparam int VF_W        = 11;
  localparam int HSE_W       = 5;
  localparam int HBE_W       = 7;
  localparam int VSE_W       = 4;
  localparam int VBE_W       = 8;
  localparam int HC_W        = HF_W + 1;
  localparam int VC_W        = VF_W + 1;
  localparam int H_LAST_OFS  = 4;   // total field is count minus 5
  localparam int V_LAST_OFS  = 1;   // total field is count minus 2

  typedef struct packed {
    logic [HF_W-1:0]  hTotal;
    logic [HF_W-1:0]  hDispEnd;
    logic [HF_W-1:0]  hBlankStart;
    logic [HF_W-1:0]  hSyncStart;
    logic [HBE_W-1:0] hBlankEnd;
    logic [HSE_W-1:0] hSyncEnd;
    logic [VF_W-1:0]  vTotal;
    logic [VF_W-1:0]  vDispEnd;
    logic [VF_W-1:0]  vBlankStart;
    logic [VF_W-1:0]  vSyncStart;
    logic [VBE_W-1:0] vBlankEnd;
    logic [VSE_W-1:0] vSyncEnd;
  } timing_cfg_t;

  typedef struct packed {
    logic clr;
    logic charEnd;
    logic lineEnd;
  } step_strobe_t;
endpackage

// File: rtl/crtc_field_decode.sv
module crtc_field_decode
  import crtc_pkg::*;
(
  input  logic [8*CR_COUNT-1:0] crBytes,
  output timing_cfg_t           cfg,
  output logic                  timingEn
);
  localparam int IX_HTOT = 8'h00, IX_HDE = 8'h01, IX_HBS = 8'h02, IX_HBE = 8'h03;
  localparam int IX_HSS  = 8'h04, IX_HSE = 8'h05, IX_VTOT = 8'h06, IX_OVF = 8'h07;
  localparam int IX_MSL  = 8'h09, IX_VSS = 8'h10, IX_VSE = 8'h11, IX_VDE = 8'h12;
  localparam int IX_VBS  = 8'h15, IX_VBE = 8'h16, IX_MODE = 8'h17;
  localparam int IX_HEXT = 8'h1A, IX_VEXT = 8'h1B;

  logic [7:0] cr [CR_COUNT];
  for (genvar i = 0; i < CR_COUNT; i++) begin : g_split
    assign cr[i] = crBytes[8*i +: 8];
  end

  logic unusedCr;
  assign unusedCr = ^crBytes;

  always_comb begin
    cfg.hTotal      = {cr[IX_HEXT][0], cr[IX_HTOT]};
    cfg.hDispEnd    = {cr[IX_HEXT][2], cr[IX_HDE]};
    cfg.hBlankStart = {cr[IX_HEXT][4], cr[IX_HBS]};
    cfg.hSyncStart  = {cr[IX_HEXT][6], cr[IX_HSS]};
    cfg.hBlankEnd   = {cr[IX_HEXT][5], cr[IX_HSE][7], cr[IX_HBE][4:0]};
    cfg.hSyncEnd    = cr[IX_HSE][4:0];
    cfg.vTotal      = {cr[IX_VEXT][0], cr[IX_OVF][5], cr[IX_OVF][0], cr[IX_VTOT]};
    cfg.vDispEnd    = {cr[IX_VEXT][2], cr[IX_OVF][6], cr[IX_OVF][1], cr[IX_VDE]};
    cfg.vSyncStart  = {cr[IX_VEXT][6], cr[IX_OVF][7], cr[IX_OVF][2], cr[IX_VSS]};
    cfg.vBlankStart = {cr[IX_VEXT][4], cr[IX_MSL][5], cr[IX_OVF][3], cr[IX_VBS]};
    cfg.vSyncEnd    = cr[IX_VSE][3:0];
    cfg.vBlankEnd   = cr[IX_VBE];
    timingEn        = cr[IX_MODE][7];
  end
endmodule

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int CHAR_NARROW = 8,
  parameter int CHAR_WIDE   = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         timingEn,
  input  logic         dblWidth,
  input  logic         hAtLast,
  output step_strobe_t stb
);
  localparam int SUB_W = $clog2(CHAR_WIDE);

  logic [SUB_W-1:0] pixSub;
  logic [SUB_W-1:0] subLast;
  logic             charEnd;

  assign subLast = dblWidth ? SUB_W'(CHAR_WIDE - 1) : SUB_W'(CHAR_NARROW - 1);
  assign charEnd = timingEn && (pixSub >= subLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pixSub <= '0;
    else if (!timingEn)       pixSub <= '0;
    else if (charEnd)         pixSub <= '0;
    else                      pixSub <= pixSub + SUB_W'(1);
  end

  assign stb.clr     = !timingEn;
  assign stb.charEnd = charEnd;
  assign stb.lineEnd = charEnd && hAtLast;

  // R8: disabled timing parks the pixel phase at zero
  a_r8_phase_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !timingEn |=> pixSub == '0);
endmodule

// File: rtl/crtc_datapath.sv
module crtc_datapath
  import crtc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  timing_cfg_t  cfg,
  input  step_strobe_t stb,
  output logic         hAtLast,
  output logic         hSyncOn,
  output logic         hBlankOn,
  output logic         vSyncOn,
  output logic         vBlankOn,
  output logic         hActive,
  output logic         vActive
);
  logic [HC_W-1:0] hCnt;
  logic [VC_W-1:0] vCnt;
  logic [HC_W-1:0] hLast;
  logic [VC_W-1:0] vLast;
  logic            vAtLast;
  logic            hSyncHeld, hBlankHeld, vSyncHeld, vBlankHeld;

  assign hLast   = {1'b0, cfg.hTotal} + HC_W'(H_LAST_OFS);
  assign vLast   = {1'b0, cfg.vTotal} + VC_W'(V_LAST_OFS);
  assign hAtLast = hCnt >= hLast;
  assign vAtLast = vCnt >= vLast;

  // start match wins; otherwise stay on until masked low bits hit the end field
  assign hSyncOn  = (hCnt == {1'b0, cfg.hSyncStart}) ||
                    (hSyncHeld && (hCnt[HSE_W-1:0] != cfg.hSyncEnd));
  assign hBlankOn = (hCnt == {1'b0, cfg.hBlankStart}) ||
                    (hBlankHeld && (hCnt[HBE_W-1:0] != cfg.hBlankEnd));
  assign vSyncOn  = (vCnt == {1'b0, cfg.vSyncStart}) ||
                    (vSyncHeld && (vCnt[VSE_W-1:0] != cfg.vSyncEnd));
  assign vBlankOn = (vCnt == {1'b0, cfg.vBlankStart}) ||
                    (vBlankHeld && (vCnt[VBE_W-1:0] != cfg.vBlankEnd));

  assign hActive = hCnt <= {1'b0, cfg.hDispEnd};
  assign vActive = vCnt <= {1'b0, cfg.vDispEnd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0; vCnt <= '0;
      hSyncHeld <= 1'b0; hBlankHeld <= 1'b0;
      vSyncHeld <= 1'b0; vBlankHeld <= 1'b0;
    end else if (stb.clr) begin
      hCnt <= '0; vCnt <= '0;
      hSyncHeld <= 1'b0; hBlankHeld <= 1'b0;
      vSyncHeld <= 1'b0; vBlankHeld <= 1'b0;
    end else begin
      if (stb.charEnd) begin
        hCnt       <= hAtLast ? '0 : hCnt + HC_W'(1);
        hSyncHeld  <= hSyncOn;
        hBlankHeld <= hBlankOn;
      end
      if (stb.lineEnd) begin
        vCnt       <= vAtLast ? '0 : vCnt + VC_W'(1);
        vSyncHeld  <= vSyncOn;
        vBlankHeld <= vBlankOn;
      end
    end
  end

  // R2: character counter steps by one except at the line wrap
  a_r2_hcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clr && stb.charEnd && !hAtLast) |=> hCnt == $past(hCnt) + HC_W'(1));

  // R3: line counter moves only on a line end
  a_r3_vcnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clr && !stb.lineEnd) |=> $stable(vCnt));

  // R5: horizontal sync changes only on character boundaries
  a_r5_hsync_char_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clr && !stb.charEnd) |=> (stb.clr || $stable(hSyncOn)));

  // R6: vertical sync changes only on line boundaries
  a_r6_vsync_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clr && !stb.lineEnd) |=> (stb.clr || $stable(vSyncOn)));

  // R8: disable clears both counters
  a_r8_counters_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clr |=> (hCnt == '0 && vCnt == '0));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int CHAR_NARROW  = 8,
  parameter int CHAR_WIDE    = 16,
  parameter int HPOL_BIT     = 6,
  parameter int VPOL_BIT     = 7
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*CR_COUNT-1:0] crRegs,
  input  logic [7:0]            miscOut,
  input  logic                  dblWidth,
  output logic                  hSyncPin,
  output logic                  vSyncPin,
  output logic                  blank,
  output logic                  displayEnable
);
  timing_cfg_t  cfg;
  step_strobe_t stb;
  logic timingEn, hAtLast;
  logic hSyncOn, hBlankOn, vSyncOn, vBlankOn, hActive, vActive;

  crtc_field_decode u_decode (
    .crBytes (crRegs),
    .cfg     (cfg),
    .timingEn(timingEn)
  );

  crtc_ctrl #(.CHAR_NARROW(CHAR_NARROW), .CHAR_WIDE(CHAR_WIDE)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .timingEn(timingEn),
    .dblWidth(dblWidth),
    .hAtLast (hAtLast),
    .stb     (stb)
  );

  crtc_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .stb     (stb),
    .hAtLast (hAtLast),
    .hSyncOn (hSyncOn),
    .hBlankOn(hBlankOn),
    .vSyncOn (vSyncOn),
    .vBlankOn(vBlankOn),
    .hActive (hActive),
    .vActive (vActive)
  );

  logic [1:0] syncRaw, syncPol, syncPins;
  assign syncRaw = {timingEn && vSyncOn, timingEn && hSyncOn};
  assign syncPol = {miscOut[VPOL_BIT], miscOut[HPOL_BIT]};

  for (genvar i = 0; i < 2; i++) begin : g_pol
    assign syncPins[i] = syncPol[i] ? syncRaw[i] : ~syncRaw[i];
  end

  logic unusedMisc;
  assign unusedMisc = ^miscOut;

  assign hSyncPin      = syncPins[0];
  assign vSyncPin      = syncPins[1];
  assign blank         = timingEn && (hBlankOn || vBlankOn);
  assign displayEnable = timingEn && hActive && vActive;
endmodule

// File: tb/crtc_timing_gen_tb_top.sv
module crtc_timing_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [223:0] crRegs = '0;
  logic [7:0]   miscOut = '0;
  logic         dblWidth = 1'b0;
  logic         hSyncPin, vSyncPin, blank, displayEnable;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  crtc_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .crRegs(crRegs), .miscOut(miscOut),
    .dblWidth(dblWidth), .hSyncPin(hSyncPin), .vSyncPin(vSyncPin),
    .blank(blank), .displayEnable(displayEnable)
  );

  typedef struct packed {
    logic        dbl;
    logic [7:0]  misc;
    logic [8:0]  hTot, hDe, hBs, hSs;
    logic [6:0]  hBe;
    logic [4:0]  hSe;
    logic [10:0] vTot, vDe, vBs, vSs;
    logic [7:0]  vBe;
    logic [3:0]  vSe;
    logic [15:0] nPix;
  } vec_t;

  // A: narrow chars (R1), neg sync, short frame (R2 R3)
  // B: wide chars, pos sync, vsync/vblank end at frame wrap
  // C: 9-bit totals via extension bits, sync start low bits equal end (R5),
  //    blank end uses bits 5 and 6, vertical starts pushed out by high bits (R10)
  // D: wide chars, sync starting at character 0 and line 0
  localparam vec_t VECS [4] = '{
    '{1'b0, 8'h00, 9'd5,   9'd6,   9'd6,   9'd7,  7'd9,    5'd9,
      11'd4, 11'd3, 11'd3,     11'd4,     8'd5, 4'd5, 16'd600},
    '{1'b1, 8'hC0, 9'd3,   9'd4,   9'd4,   9'd5,  7'd7,    5'd7,
      11'd2, 11'd2, 11'd3,     11'd3,     8'd0, 4'd0, 16'd600},
    '{1'b0, 8'h40, 9'h100, 9'h100, 9'd100, 9'd32, 7'h70,   5'd0,
      11'd1, 11'd0, 11'h402,   11'h101,   8'd3, 4'd3, 16'd6300},
    '{1'b1, 8'h80, 9'd2,   9'd6,   9'd9,   9'd0,  7'd2,    5'd2,
      11'd0, 11'd0, 11'd1,     11'd0,     8'd0, 4'd1, 16'd300}
  };

  // R10 byte placement, written from the requirement
  function automatic logic [223:0] packRegs(vec_t v, bit en);
    logic [223:0] r;
    r = '0;
    r[8*8'h00 +: 8] = v.hTot[7:0];
    r[8*8'h01 +: 8] = v.hDe[7:0];
    r[8*8'h02 +: 8] = v.hBs[7:0];
    r[8*8'h03 +: 8] = {3'b000, v.hBe[4:0]};
    r[8*8'h04 +: 8] = v.hSs[7:0];
    r[8*8'h05 +: 8] = {v.hBe[5], 2'b00, v.hSe};
    r[8*8'h06 +: 8] = v.vTot[7:0];
    r[8*8'h07 +: 8] = {v.vSs[9], v.vDe[9], v.vTot[9], 1'b0,
                       v.vBs[8], v.vSs[8], v.vDe[8], v.vTot[8]};
    r[8*8'h09 +: 8] = {2'b00, v.vBs[9], 5'b00000};
    r[8*8'h10 +: 8] = v.vSs[7:0];
    r[8*8'h11 +: 8] = {4'h0, v.vSe};
    r[8*8'h12 +: 8] = v.vDe[7:0];
    r[8*8'h15 +: 8] = v.vBs[7:0];
    r[8*8'h16 +: 8] = v.vBe;
    r[8*8'h17 +: 8] = {en, 7'b0};
    r[8*8'h1A +: 8] = {1'b0, v.hSs[8], v.hBe[6], v.hBs[8], 1'b0, v.hDe[8], 1'b0, v.hTot[8]};
    r[8*8'h1B +: 8] = {1'b0, v.vSs[10], 1'b0, v.vBs[10], 1'b0, v.vDe[10], 1'b0, v.vTot[10]};
    return r;
  endfunction

  // on from the start position until the first later position whose low bits match
  function automatic bit spanOn(int unsigned pos, int unsigned st, int unsigned en, int unsigned bits);
    if (pos < st) return 1'b0;
    for (int unsigned k = st + 1; k <= pos; k++)
      if ((k % (32'd1 << bits)) == en) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // called right after timing is enabled at a falling edge
  task automatic runPixels(vec_t v, int unsigned nPix);
    int unsigned charW, hTotal, vTotal, c, l;
    bit hs, vs, hb, vb, de;
    charW  = v.dbl ? 16 : 8;            // R1
    hTotal = 32'(v.hTot) + 5;           // R2
    vTotal = 32'(v.vTot) + 2;           // R3
    for (int unsigned p = 0; p < nPix; p++) begin
      #1;
      c  = (p / charW) % hTotal;
      l  = (p / (charW * hTotal)) % vTotal;
      hs = spanOn(c, 32'(v.hSs), 32'(v.hSe), 5);
      vs = spanOn(l, 32'(v.vSs), 32'(v.vSe), 4);
      hb = spanOn(c, 32'(v.hBs), 32'(v.hBe), 7);
      vb = spanOn(l, 32'(v.vBs), 32'(v.vBe), 8);
      de = (c <= 32'(v.hDe)) && (l <= 32'(v.vDe));
      chk("R5 R9 R1 R2 hsync",   hSyncPin, v.misc[6] ? hs : !hs);
      chk("R6 R9 R3 vsync",      vSyncPin, v.misc[7] ? vs : !vs);
      chk("R7 R10 blank",        blank, hb | vb);
      chk("R4 R10 displayEnable", displayEnable, de);
      @(negedge clk);
    end
  endtask

  task automatic chkIdle(string tag, logic [7:0] misc);
    #1;
    chk(tag, hSyncPin, !misc[6]);
    chk(tag, vSyncPin, !misc[7]);
    chk(tag, blank, 1'b0);
    chk(tag, displayEnable, 1'b0);
  endtask

  task automatic loadAndRun(vec_t v, int unsigned nPix);
    @(negedge clk);
    dblWidth = v.dbl;
    miscOut  = v.misc;
    crRegs   = packRegs(v, 1'b0);
    @(negedge clk);
    @(negedge clk);
    crRegs = packRegs(v, 1'b1);
    runPixels(v, nPix);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // reset state, negative polarity: pins idle high (R8)
    @(negedge clk);
    chkIdle("R8 reset idle", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VECS[i]) loadAndRun(VECS[i], 32'(VECS[i].nPix));

    // R8: drop the enable mid-line, outputs go idle and counters restart from zero
    loadAndRun(VECS[0], 125);
    crRegs = packRegs(VECS[0], 1'b0);
    chkIdle("R8 disabled idle", VECS[0].misc);
    repeat (3) @(negedge clk);
    chkIdle("R8 disabled held", VECS[0].misc);
    @(negedge clk);
    crRegs = packRegs(VECS[0], 1'b1);
    runPixels(VECS[0], 200);

    // R9: with timing off, positive polarity makes idle pins low
    @(negedge clk);
    miscOut = 8'hC0;
    crRegs  = packRegs(VECS[1], 1'b0);
    chkIdle("R9 R8 idle positive", 8'hC0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule